// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block is the write-side controller of a byte-wide nonvolatile memory. It decodes the active-low chip-enable, write-enable and output-enable inputs into read, write, standby and inhibit modes. A write is strobed by whichever of chip enable or write enable starts last and ends first. Each qualified write strobe places its byte into a page buffer. The page is fixed by the first byte of the operation, and later bytes fill only their own slot within that page.

A retriggerable byte-load timer begins when each write strobe ends. The next strobe start cancels it. If the timer runs out, the block enters a self-timed program cycle. That cycle copies every slot marked valid into the behavioural storage array, one slot per clock, and then clears the valid flags. During the cycle a busy output is high and all write strobes are ignored. A read during the cycle returns a status byte in place of the data. Writes are also locked out for a fixed window after reset, whenever the supply-valid input is low, and for strobes that are too short.

All inputs pass through one register stage. The array read is synchronous and the output is registered, so read data appears three clock edges after the inputs change. Sizes and all time windows are parameters counted in clock cycles.

Top module: `pg_eeprom_ctrl`

## Requirements
- R1: Write strobes that end within PWRUP_CYC clock cycles after reset release are ignored: no program cycle starts and busy stays low.
- R2: While supply_ok is low, write strobes are ignored: no program cycle starts.
- R3: dout_en goes high three clock edges after ce_n=0, oe_n=0 and we_n=1 are applied, and it is low in every other mode. After reset, dout_en and busy are low.
- R4: The write strobe is active while ce_n=0, we_n=0 and oe_n=1. Framing the strobe with write enable gives the same result as framing it with chip enable. With oe_n=0 no byte is loaded.
- R5: A strobe that is active for fewer than GLITCH_MIN clock cycles loads nothing. At least GLITCH_MIN cycles are needed for a load.
- R6: The program cycle starts (busy rises) only after BLC_CYC cycles pass with no new strobe since the end of the last one. A strobe start inside that window stops the timer, so loads spaced closer than BLC_CYC extend one page operation.
- R7: All bytes of one operation go to the page (upper address bits above the low PW bits) latched from the first load. Each byte lands at the offset given by its own low PW address bits.
- R8: Only slots loaded in the current operation are written to the array. Other addresses in the page keep their contents.
- R9: busy stays high for exactly PROG_CYC cycles. Write strobes during busy are ignored and start no later operation.
- R10: A read while busy returns the complement of bit 7 of the last loaded byte on bit 7, a bit 6 that changes between successive reads, and zero on bits 5..0.
- R11: After the cycle ends, reads return the array data. The valid flags are cleared, so a later operation on another page writes only its own slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| supply_ok | input | 1 | High when the supply is above the write threshold |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| dout | output | DW | Registered read data or status byte, zero when not driven |
| dout_en | output | 1 | Output drive enable (low means high impedance) |
| busy | output | 1 | Self-timed program cycle in progress |

## Verification
A stuck or misloaded valid flag shows up at the ports as a changed byte at an address nobody wrote. This is visible on the first read after the following program cycle. A wrong page latch puts data at the wrong address within that same cycle. A byte-load timer that miscounts, or that does not restart or cancel correctly, moves the rising edge of busy. The bench sees this within one load window. Faults in strobe qualification, such as glitch rejection, inhibit or the busy lockout, appear either as a program cycle that should not occur or as the loss of a known older value at the next read.

// File: rtl/pge_pkg.sv
package pge_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} seq_st_t;
endpackage

// File: rtl/pge_strobe.sv
module pge_strobe #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int GLITCH_MIN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          supply_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          strb_act,
  output logic          strb_start,
  output logic          strb_end,
  output logic          strb_long,
  output logic          rd_mode,
  output logic          rd_start,
  output logic          sup_q,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  localparam int WCW = $clog2(GLITCH_MIN + 1);
  localparam logic [WCW-1:0] WMAX = WCW'(GLITCH_MIN);

  logic          ce_q, we_q, oe_q, strb_q, rd_q;
  logic [DW-1:0] din_q;
  logic [WCW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1; sup_q <= 1'b0;
      strb_q <= 1'b0; rd_q <= 1'b0; wcnt <= '0;
      addr_q <= '0; din_q <= '0; cap_addr <= '0; cap_data <= '0;
    end else begin
      ce_q <= ce_n; we_q <= we_n; oe_q <= oe_n; sup_q <= supply_ok;
      addr_q <= addr; din_q <= din;
      strb_q <= strb_act;
      rd_q <= rd_mode;
      if (strb_start) wcnt <= WCW'(1);
      else if (strb_act && wcnt != WMAX) wcnt <= wcnt + WCW'(1);
      if (strb_act) begin
        cap_addr <= addr_q;
        cap_data <= din_q;
      end
    end
  end

  // strobe window: last enable to fall opens it, first to rise closes it
  assign strb_act   = !ce_q && !we_q && oe_q;
  assign strb_start = strb_act && !strb_q;
  assign strb_end   = !strb_act && strb_q;
  assign strb_long  = (wcnt >= WMAX);
  assign rd_mode    = !ce_q && !oe_q && we_q;
  assign rd_start   = rd_mode && !rd_q;
endmodule

// File: rtl/pge_seq.sv
module pge_seq
  import pge_pkg::*;
#(
  parameter int PW = 7,
  parameter int BLC_CYC = 80,
  parameter int PROG_CYC = 300,
  parameter int PWRUP_CYC = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_start,
  input  logic          strb_end,
  input  logic          strb_long,
  input  logic          sup_q,
  input  logic          rd_start,
  input  logic          cap_msb,
  output logic          ld_we,
  output logic          ld_first,
  output logic          busy,
  output logic          cmt_act,
  output logic [PW-1:0] cmt_idx,
  output logic          clr_valid,
  output logic          last_msb,
  output logic          tog
);
  localparam int BCW = $clog2(BLC_CYC + 1);
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int UCW = $clog2(PWRUP_CYC + 1);
  localparam logic [BCW-1:0] BLC_LAST  = BCW'(BLC_CYC - 1);
  localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);
  localparam logic [PCW-1:0] PAGE_LIM  = PCW'(2 ** PW);
  localparam logic [UCW-1:0] PWR_LIM   = UCW'(PWRUP_CYC);

  seq_st_t        st;
  logic [BCW-1:0] blc_cnt;
  logic           blc_run;
  logic [PCW-1:0] prog_cnt;
  logic [UCW-1:0] pwr_cnt;
  logic           inhibit;

  assign inhibit  = (pwr_cnt != PWR_LIM) || !sup_q;
  assign ld_we    = strb_end && strb_long && !inhibit && (st != ST_PROG);
  assign ld_first = ld_we && (st == ST_IDLE);
  // the commit walk needs PROG_CYC larger than the page size plus two
  assign cmt_act   = (st == ST_PROG) && (prog_cnt < PAGE_LIM);
  assign cmt_idx   = prog_cnt[PW-1:0];
  assign clr_valid = (st == ST_PROG) && (prog_cnt == PROG_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; blc_run <= 1'b0; blc_cnt <= '0;
      prog_cnt <= '0; pwr_cnt <= '0; last_msb <= 1'b0; tog <= 1'b0;
    end else begin
      if (pwr_cnt != PWR_LIM) pwr_cnt <= pwr_cnt + UCW'(1);
      if (ld_we) last_msb <= cap_msb;
      if (rd_start && busy) tog <= !tog;
      case (st)
        ST_IDLE: begin
          if (ld_we) begin
            st <= ST_LOAD; blc_run <= 1'b1; blc_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (strb_end) begin
            blc_run <= 1'b1; blc_cnt <= '0;
          end else if (strb_start) begin
            blc_run <= 1'b0;
          end else if (blc_run) begin
            if (blc_cnt == BLC_LAST) begin
              st <= ST_PROG; busy <= 1'b1; prog_cnt <= '0;
              tog <= 1'b0; blc_run <= 1'b0;
            end else begin
              blc_cnt <= blc_cnt + BCW'(1);
            end
          end
        end
        ST_PROG: begin
          prog_cnt <= prog_cnt + PCW'(1);
          if (prog_cnt == PROG_LAST) begin
            st <= ST_IDLE; busy <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pge_pagebuf.sv
module pge_pagebuf #(
  parameter int AW = 11,
  parameter int PW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic          ld_first,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          cmt_act,
  input  logic [PW-1:0] cmt_idx,
  input  logic          clr_valid,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);
  localparam int PAGE = 2 ** PW;
  localparam int GW = AW - PW;

  logic [DW-1:0] slot_mem [PAGE];
  logic [PAGE-1:0] valid;
  logic [GW-1:0] page_q;
  logic [PW-1:0] idx_q;
  logic          vq;

  always_ff @(posedge clk) begin
    if (ld_we) slot_mem[ld_addr[PW-1:0]] <= ld_data;
    arr_data <= slot_mem[cmt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0; page_q <= '0; idx_q <= '0; vq <= 1'b0;
    end else begin
      if (clr_valid) valid <= '0;
      else if (ld_we) valid[ld_addr[PW-1:0]] <= 1'b1;
      if (ld_first) page_q <= ld_addr[AW-1:PW];
      idx_q <= cmt_idx;
      vq <= cmt_act && valid[cmt_idx];
    end
  end

  assign arr_we   = vq;
  assign arr_addr = {page_q, idx_q};
endmodule

// File: rtl/pge_array.sv
module pge_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2 ** AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pg_eeprom_ctrl.sv
module pg_eeprom_ctrl #(
  parameter int AW = 11,
  parameter int PW = 7,
  parameter int DW = 8,
  parameter int GLITCH_MIN = 3,
  parameter int BLC_CYC = 80,
  parameter int PROG_CYC = 300,
  parameter int PWRUP_CYC = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          supply_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy
);
  logic          strb_act, strb_start, strb_end, strb_long, rd_mode, rd_start, sup_q;
  logic [AW-1:0] addr_q, cap_addr;
  logic [DW-1:0] cap_data;
  logic          ld_we, ld_first, cmt_act, clr_valid, last_msb, tog;
  logic [PW-1:0] cmt_idx;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data, arr_rdata;
  logic          rd_q2;

  pge_strobe #(.AW(AW), .DW(DW), .GLITCH_MIN(GLITCH_MIN)) strobe_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .supply_ok(supply_ok), .addr(addr), .din(din),
    .strb_act(strb_act), .strb_start(strb_start), .strb_end(strb_end),
    .strb_long(strb_long), .rd_mode(rd_mode), .rd_start(rd_start),
    .sup_q(sup_q), .addr_q(addr_q), .cap_addr(cap_addr), .cap_data(cap_data));

  pge_seq #(.PW(PW), .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC),
            .PWRUP_CYC(PWRUP_CYC)) seq_i (
    .clk(clk), .rst(rst), .strb_start(strb_start), .strb_end(strb_end),
    .strb_long(strb_long), .sup_q(sup_q), .rd_start(rd_start),
    .cap_msb(cap_data[DW-1]), .ld_we(ld_we), .ld_first(ld_first),
    .busy(busy), .cmt_act(cmt_act), .cmt_idx(cmt_idx),
    .clr_valid(clr_valid), .last_msb(last_msb), .tog(tog));

  pge_pagebuf #(.AW(AW), .PW(PW), .DW(DW)) pbuf_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_first(ld_first),
    .ld_addr(cap_addr), .ld_data(cap_data), .cmt_act(cmt_act),
    .cmt_idx(cmt_idx), .clr_valid(clr_valid), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data));

  pge_array #(.AW(AW), .DW(DW)) array_i (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_data),
    .raddr(addr_q), .rdata(arr_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q2 <= 1'b0; dout_en <= 1'b0; dout <= '0;
    end else begin
      rd_q2 <= rd_mode;
      dout_en <= rd_q2;
      if (!rd_q2) dout <= '0;
      else if (busy) dout <= {!last_msb, tog, {(DW-2){1'b0}}};
      else dout <= arr_rdata;
    end
  end
endmodule

// File: rtl/pge_chk.sv
module pge_chk #(
  parameter int DW = 8,
  parameter int PROG_CYC = 300
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          busy,
  input logic          dout_en,
  input logic [DW-1:0] dout,
  input logic          last_msb,
  input logic          arr_we,
  input logic          strb_act
);
  localparam int BLW = $clog2(PROG_CYC + 2);
  logic [BLW-1:0] bl_cnt;

  always_ff @(posedge clk) begin
    if (rst) bl_cnt <= '0;
    else if (busy) bl_cnt <= bl_cnt + BLW'(1);
    else bl_cnt <= '0;
  end

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bl_cnt == BLW'(PROG_CYC));

  // R3
  rd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!ce_n && !oe_n && we_n, 3));

  // R3
  rd_hz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n || oe_n, 3) |-> !dout_en);

  // R10
  poll_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(busy)) |-> dout[DW-1] == !$past(last_msb));

  // R8
  commit_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R6
  start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(strb_act));
endmodule

bind pg_eeprom_ctrl pge_chk #(.DW(DW), .PROG_CYC(PROG_CYC)) chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .dout_en(dout_en), .dout(dout), .last_msb(last_msb),
  .arr_we(arr_we), .strb_act(strb_act));

// File: tb/pg_eeprom_ctrl_tb_top.sv
module pg_eeprom_ctrl_tb_top;
  localparam int AW = 11, PW = 7, DW = 8;
  localparam int GLITCH_MIN = 3, BLC_CYC = 80, PROG_CYC = 300, PWRUP_CYC = 120;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  pg_eeprom_ctrl #(.AW(AW), .PW(PW), .DW(DW), .GLITCH_MIN(GLITCH_MIN),
    .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC), .PWRUP_CYC(PWRUP_CYC)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .supply_ok(supply_ok), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int w, input bit cectl, input bit oe_low);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1;
    if (cectl) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    if (cectl) ce_n = 1'b0; else we_n = 1'b0;
    repeat (w) @(negedge clk);
    if (cectl) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (4) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] d; logic en;
    rd_byte(a, d, en);
    chk(en === 1'b1 && d === exp, tag, int'(d), int'(exp));
  endtask

  // waits for busy to rise, then measures its length
  task automatic run_prog(input string tag);
    int t = 0, len = 0;
    while (busy !== 1'b1 && t < 4 * BLC_CYC) begin @(negedge clk); t++; end
    chk(busy === 1'b1, tag, int'(busy), 1);
    while (busy === 1'b1 && len < 2 * PROG_CYC) begin @(negedge clk); len++; end
    chk(len == PROG_CYC, "R9 busy length", len, PROG_CYC);
  endtask

  task automatic no_prog(input string tag);
    bit seen = 1'b0;
    repeat (BLC_CYC + 20) begin @(negedge clk); if (busy !== 1'b0) seen = 1'b1; end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic t_reset;
    chk(dout_en === 1'b0, "R3 dout_en after reset", int'(dout_en), 0);
    chk(busy === 1'b0, "R3 busy after reset", int'(busy), 0);
  endtask

  task automatic t_powerup;
    wr_byte(11'h010, 8'h5A, 4, 1'b0, 1'b0);
    no_prog("R1 write in power-up window");
  endtask

  task automatic t_byte_modes;
    logic [DW-1:0] d; logic en;
    wr_byte(11'h123, 8'h3C, 4, 1'b0, 1'b0);
    repeat (BLC_CYC - 10) @(negedge clk);
    chk(busy === 1'b0, "R6 busy before load window ends", int'(busy), 0);
    run_prog("R6 program after load window");
    rd_chk(11'h123, 8'h3C, "R4 WE-framed byte");
    wr_byte(11'h124, 8'hA5, 4, 1'b1, 1'b0);
    run_prog("R4 CE-framed start");
    rd_chk(11'h124, 8'hA5, "R4 CE-framed byte");
    wr_byte(11'h124, 8'h00, 4, 1'b0, 1'b1);
    no_prog("R4 oe low during strobe");
    rd_chk(11'h124, 8'hA5, "R4 oe low keeps data");
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_en === 1'b0, "R3 no drive with oe high", int'(dout_en), 0);
    ce_n = 1'b1; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(dout_en === 1'b0, "R3 no drive in standby", int'(dout_en), 0);
    oe_n = 1'b1;
    rd_byte(11'h123, d, en);
    chk(en === 1'b1, "R3 drive in read mode", int'(en), 1);
  endtask

  task automatic t_page;
    wr_byte(11'h200, 8'h11, 4, 1'b0, 1'b0);
    repeat (BLC_CYC / 2) @(negedge clk);
    wr_byte(11'h205, 8'h22, 4, 1'b0, 1'b0);
    repeat (BLC_CYC / 2) @(negedge clk);
    wr_byte(11'h27F, 8'h33, 4, 1'b1, 1'b0);
    repeat (BLC_CYC / 2) @(negedge clk);
    chk(busy === 1'b0, "R6 retrigger keeps page open", int'(busy), 0);
    wr_byte(11'h0B0, 8'h44, 4, 1'b0, 1'b0);
    run_prog("R6 page program start");
    rd_chk(11'h200, 8'h11, "R7 slot 0");
    rd_chk(11'h205, 8'h22, "R7 slot 5");
    rd_chk(11'h27F, 8'h33, "R7 slot 127");
    rd_chk(11'h230, 8'h44, "R7 foreign page byte to first page");
  endtask

  task automatic t_glitch;
    wr_byte(11'h205, 8'h77, 4, 1'b0, 1'b0);
    wr_byte(11'h200, 8'hEE, GLITCH_MIN - 1, 1'b0, 1'b0);
    run_prog("R5 glitch op start");
    rd_chk(11'h205, 8'h77, "R5 loaded byte");
    rd_chk(11'h200, 8'h11, "R5 short strobe ignored");
    rd_chk(11'h27F, 8'h33, "R8 unloaded slot kept");
    wr_byte(11'h210, 8'h99, GLITCH_MIN - 1, 1'b0, 1'b0);
    no_prog("R5 lone short strobe");
  endtask

  task automatic t_clear;
    wr_byte(11'h600, 8'hC0, 4, 1'b0, 1'b0);
    run_prog("R11 op0");
    wr_byte(11'h500, 8'h10, 4, 1'b0, 1'b0);
    wr_byte(11'h501, 8'h20, 4, 1'b0, 1'b0);
    run_prog("R11 op1");
    wr_byte(11'h601, 8'h61, 4, 1'b0, 1'b0);
    run_prog("R11 op2");
    rd_chk(11'h600, 8'hC0, "R11 stale slot not rewritten");
    rd_chk(11'h601, 8'h61, "R11 new slot");
    rd_chk(11'h501, 8'h20, "R11 earlier page intact");
  endtask

  task automatic t_poll;
    logic [DW-1:0] r1, r2; logic e1, e2; int t = 0;
    wr_byte(11'h300, 8'h81, 4, 1'b0, 1'b0);
    while (busy !== 1'b1 && t < 4 * BLC_CYC) begin @(negedge clk); t++; end
    rd_byte(11'h300, r1, e1);
    rd_byte(11'h300, r2, e2);
    chk(e1 === 1'b1 && r1[7] === 1'b0 && r1[5:0] === 6'd0, "R10 poll byte", int'(r1), 0);
    chk(r1[6] !== r2[6], "R10 toggle bit changes", int'(r2[6]), int'(!r1[6]));
    wr_byte(11'h300, 8'h00, 4, 1'b0, 1'b0);
    while (busy === 1'b1) @(negedge clk);
    rd_chk(11'h300, 8'h81, "R11 true data after cycle");
    no_prog("R9 strobe during busy ignored");
    rd_chk(11'h300, 8'h81, "R9 busy write lost");
  endtask

  task automatic t_supply;
    supply_ok = 1'b0;
    wr_byte(11'h302, 8'h5C, 4, 1'b0, 1'b0);
    no_prog("R2 write with supply low");
    supply_ok = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_powerup();
    repeat (PWRUP_CYC) @(negedge clk);
    t_byte_modes();
    t_page();
    t_glitch();
    t_clear();
    t_poll();
    t_supply();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule